// File: doc/BRIEF.md
# Column-Compression 4x4 Unsigned Multiplier

This block multiplies two 4-bit unsigned operands and returns their 8-bit product. It first builds sixteen partial-product bits with AND gates. It then compresses the weighted columns in two stages until only two rows are left, and adds those two rows with a ripple-carry adder. The compression uses full-adder cells almost everywhere. A single half adder sits at the one column where leaving it out would force a third stage.

Every full-adder cell is a pair of 2:1 selects, and both selects are steered by the exclusive-or of two of the cell's inputs. A parameter switches the cells to a plain gate form instead, so the two forms can be compared. Another parameter adds an output register for timing closure. Without that register the block is pure logic, and the clock and reset pins have no effect on the product.

Top module: `rcw_mult`

## Requirements
- R1: For every one of the 256 operand pairs, the product output equals the unsigned product of the two operands.
- R2: Operand bit i of x combined with bit j of y contributes weight 2^(i+j). So x = 2^i and y = 2^j give a product of exactly 2^(i+j).
- R3: Each full-adder cell computes sel = b XOR c. When sel is 0, sum = a and carry = b. When sel is 1, sum = NOT a and carry = a. Its {carry, sum} always equals a + b + c.
- R4: The two compression stages preserve the weighted column sum, and the final adder drops any carry beyond bit 7. At the largest input, 15 x 15 gives 225 (binary 11100001).
- R5: If either operand is zero, the product is zero.
- R6: If one operand is 1, the product equals the other operand.
- R7: With REG_OUT = 0, the product follows the operands in the same cycle, with no storage, and is not affected by clk or rst_n.
- R8: With REG_OUT = 1, the product for operands sampled at a rising clk edge is available right after that edge, which means one cycle of latency. While rst_n is low (active low, asynchronous), the product reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the optional output register |
| x | input | OP_W (4) | Multiplicand, unsigned |
| y | input | OP_W (4) | Multiplier, unsigned |
| p | output | 2*OP_W (8) | Product, unsigned |

## Verification
The combinational variant's product is due in the same cycle as its operands. The registered variant's product is due one rising edge after the operands are applied. The driver changes the operands on the falling edge and queues the expected product. The monitor pops that expectation 1 ns after the next rising edge, when both variants hold that operand pair's product. Both instances are compared against the same queued value. Before release, a check under reset confirms that the registered output reads zero while the combinational output already carries 15 x 15.

// File: rtl/rcw_pkg.sv
package rcw_pkg;

   typedef enum logic {
      FA_MUX   = 1'b0,
      FA_LOGIC = 1'b1
   } fa_style_e;

   localparam int unsigned SUPPORTED_OP_W = 4;

endpackage

// File: rtl/rcw_fa_cell.sv
module rcw_fa_cell #(
   parameter rcw_pkg::fa_style_e STYLE = rcw_pkg::FA_MUX
) (
   input  logic a,
   input  logic b,
   input  logic c,
   output logic s,
   output logic co
);

   generate
      if (STYLE == rcw_pkg::FA_MUX) begin : g_mux
         logic sel;
         assign sel = b ^ c;
         // two 2:1 selects share one steering signal
         assign s  = sel ? ~a : a;
         assign co = sel ? a  : b;
      end else begin : g_logic
         assign s  = a ^ b ^ c;
         assign co = (a & b) | (a & c) | (b & c);
      end
   endgenerate

   always_comb begin
      if (!$isunknown({a, b, c})) begin
         p_fa_truth_r3: assert ({co, s} == (2'(a) + 2'(b) + 2'(c)))
            else $error("R3 full-adder cell result mismatch");
      end
   end

endmodule

// File: rtl/rcw_ha_cell.sv
module rcw_ha_cell (
   input  logic a,
   input  logic b,
   output logic s,
   output logic co
);

   assign s  = a ^ b;
   assign co = a & b;

   always_comb begin
      if (!$isunknown({a, b})) begin
         p_ha_truth_r4: assert ({co, s} == (2'(a) + 2'(b)))
            else $error("R4 half-adder cell result mismatch");
      end
   end

endmodule

// File: rtl/rcw_ppgen.sv
module rcw_ppgen #(
   parameter int unsigned AW = 4,
   parameter int unsigned BW = 4
) (
   input  logic [AW-1:0]          x,
   input  logic [BW-1:0]          y,
   output logic [BW-1:0][AW-1:0]  pp
);

   generate
      for (genvar j = 0; j < BW; j++) begin : g_row
         for (genvar i = 0; i < AW; i++) begin : g_bit
            // row j, bit i carries weight i+j
            assign pp[j][i] = x[i] & y[j];
         end
      end
   endgenerate

endmodule

// File: rtl/rcw_reduce4.sv
module rcw_reduce4 #(
   parameter int unsigned        OP_W  = 4,
   parameter rcw_pkg::fa_style_e STYLE = rcw_pkg::FA_MUX,
   localparam int unsigned       RW    = 2 * OP_W - 1
) (
   input  logic [OP_W-1:0][OP_W-1:0] pp,
   output logic [RW-1:0]             row_a,
   output logic [RW-1:0]             row_b
);

   generate
      if (OP_W != rcw_pkg::SUPPORTED_OP_W) begin : g_bad_width
         $error("rcw_reduce4 supports only a 4-bit operand width");
      end
   endgenerate

   // stage one: rows 0..2 compressed, row 3 passes through
   logic s1, c1, s2, c2, s3, c3;

   rcw_fa_cell #(.STYLE(STYLE)) u_st1_col2 (
      .a(pp[0][2]), .b(pp[1][1]), .c(pp[2][0]), .s(s1), .co(c1));
   rcw_fa_cell #(.STYLE(STYLE)) u_st1_col3 (
      .a(pp[0][3]), .b(pp[1][2]), .c(pp[2][1]), .s(s2), .co(c2));
   // the lone two-bit add: keeps column 4 at height three after stage one
   rcw_ha_cell u_st1_col4 (
      .a(pp[1][3]), .b(pp[2][2]), .s(s3), .co(c3));

   // stage two: columns 3..5 each hold three bits
   logic s4, c4, s5, c5, s6, c6;

   rcw_fa_cell #(.STYLE(STYLE)) u_st2_col3 (
      .a(s2), .b(c1), .c(pp[3][0]), .s(s4), .co(c4));
   rcw_fa_cell #(.STYLE(STYLE)) u_st2_col4 (
      .a(s3), .b(c2), .c(pp[3][1]), .s(s5), .co(c5));
   rcw_fa_cell #(.STYLE(STYLE)) u_st2_col5 (
      .a(pp[2][3]), .b(c3), .c(pp[3][2]), .s(s6), .co(c6));

   assign row_a = {pp[3][3], s6, s5, s4, s1, pp[0][1], pp[0][0]};
   assign row_b = {c6, c5, c4, 1'b0, 1'b0, pp[1][0], 1'b0};

   // weighted column sum must survive both stages
   logic [RW:0] weight_in;
   always_comb begin
      weight_in = '0;
      for (int j = 0; j < int'(OP_W); j++) begin
         for (int i = 0; i < int'(OP_W); i++) begin
            weight_in = weight_in + ((RW+1)'(pp[j][i]) << (i + j));
         end
      end
   end

   always_comb begin
      if (!$isunknown(pp)) begin
         p_weight_kept_r4: assert (((RW+1)'(row_a) + (RW+1)'(row_b)) == weight_in)
            else $error("R4 column compression lost weight");
      end
   end

endmodule

// File: rtl/rcw_ripple.sv
module rcw_ripple #(
   parameter int unsigned        N     = 8,
   parameter rcw_pkg::fa_style_e STYLE = rcw_pkg::FA_MUX
) (
   input  logic [N-1:0] a,
   input  logic [N-1:0] b,
   input  logic         cin,
   output logic [N-1:0] sum,
   output logic         cout
);

   logic [N:0] carry;
   assign carry[0] = cin;

   generate
      for (genvar k = 0; k < N; k++) begin : g_stage
         rcw_fa_cell #(.STYLE(STYLE)) u_fa (
            .a(a[k]), .b(b[k]), .c(carry[k]), .s(sum[k]), .co(carry[k+1]));
      end
   endgenerate

   assign cout = carry[N];

   always_comb begin
      if (!$isunknown({a, b, cin})) begin
         p_ripple_sum_r4: assert ({cout, sum} == ((N+1)'(a) + (N+1)'(b) + (N+1)'(cin)))
            else $error("R4 ripple adder mismatch");
      end
   end

endmodule

// File: rtl/rcw_mult.sv
module rcw_mult #(
   parameter int unsigned        OP_W     = 4,
   parameter bit                 REG_OUT  = 1'b0,
   parameter rcw_pkg::fa_style_e FA_STYLE = rcw_pkg::FA_MUX,
   localparam int unsigned       PW       = 2 * OP_W,
   localparam int unsigned       RW       = PW - 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [OP_W-1:0] x,
   input  logic [OP_W-1:0] y,
   output logic [PW-1:0]   p
);

   logic [OP_W-1:0][OP_W-1:0] pp;
   logic [RW-1:0]             row_a, row_b;
   logic [PW-1:0]             prod;
   logic                      unused_cout;

   rcw_ppgen #(.AW(OP_W), .BW(OP_W)) u_ppgen (
      .x(x), .y(y), .pp(pp));

   rcw_reduce4 #(.OP_W(OP_W), .STYLE(FA_STYLE)) u_reduce (
      .pp(pp), .row_a(row_a), .row_b(row_b));

   // carry out of the top bit is always zero for an in-range product
   rcw_ripple #(.N(PW), .STYLE(FA_STYLE)) u_cpa (
      .a({1'b0, row_a}), .b({1'b0, row_b}), .cin(1'b0),
      .sum(prod), .cout(unused_cout));

   generate
      if (REG_OUT) begin : g_reg
         logic [PW-1:0] p_q;
         logic          armed_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               p_q     <= '0;
               armed_q <= 1'b0;
            end else begin
               p_q     <= prod;
               armed_q <= 1'b1;
            end
         end

         assign p = p_q;

         p_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
            armed_q |-> p == $past(PW'(x) * PW'(y)))
            else $error("R8 registered product latency wrong");

         p_reset_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(rst_n) |-> p == '0)
            else $error("R8 product not cleared by reset");
      end else begin : g_comb
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
         assign p = prod;

         p_same_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
            p == PW'(x) * PW'(y))
            else $error("R7 combinational product wrong");

         p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (x == '0 || y == '0) |-> p == '0)
            else $error("R5 zero operand gave nonzero product");

         p_unit_operand_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (x == OP_W'(1)) |-> p == PW'(y))
            else $error("R6 unit operand product wrong");
      end
   endgenerate

endmodule

// File: tb/rcw_mult_bench.sv
module rcw_mult_bench;

   localparam int unsigned OP_W = 4;
   localparam int unsigned PW   = 2 * OP_W;

   typedef struct {
      logic [OP_W-1:0] xa;
      logic [OP_W-1:0] yb;
      logic [PW-1:0]   exp;
      string           tag;
   } sb_item_t;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [OP_W-1:0] x = '0;
   logic [OP_W-1:0] y = '0;
   logic [PW-1:0]   p_reg, p_comb;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;
   sb_item_t sbq[$];

   always #2 clk = ~clk;

   rcw_mult #(.OP_W(OP_W), .REG_OUT(1'b1)) u_rcw_mult (
      .clk(clk), .rst_n(rst_n), .x(x), .y(y), .p(p_reg));

   rcw_mult #(.OP_W(OP_W), .REG_OUT(1'b0)) u_rcw_mult_comb (
      .clk(clk), .rst_n(rst_n), .x(x), .y(y), .p(p_comb));

   task automatic check(string tag, logic [PW-1:0] act, logic [PW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic drive(logic [OP_W-1:0] a, logic [OP_W-1:0] b, string tag);
      sb_item_t it;
      @(negedge clk);
      x = a;
      y = b;
      it.xa  = a;
      it.yb  = b;
      it.exp = PW'(a) * PW'(b);
      it.tag = tag;
      sbq.push_back(it);
   endtask

   // monitor: each queued pair is due 1 ns after the next rising edge
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sbq.size() > 0) begin
            sb_item_t it;
            it = sbq.pop_front();
            check({it.tag, " registered"}, p_reg, it.exp);
            check({it.tag, " combinational"}, p_comb, it.exp);
         end
      end
   end

   initial begin
      // reset phase: registered output held at 0, combinational already live
      x = 4'd15;
      y = 4'd15;
      repeat (3) @(posedge clk);
      #1;
      check("R8 reset clears registered product", p_reg, 8'd0);
      check("R7 combinational ignores reset", p_comb, 8'd225);
      @(negedge clk);
      rst_n = 1'b1;

      // R1: exhaustive sweep
      for (int a = 0; a < 16; a++) begin
         for (int b = 0; b < 16; b++) begin
            drive(4'(a), 4'(b), "R1");
         end
      end
      // R2: single-bit operands land at weight i+j
      for (int i = 0; i < 4; i++) begin
         for (int j = 0; j < 4; j++) begin
            drive(4'(1 << i), 4'(1 << j), "R2");
         end
      end
      // R5: zero on either side
      for (int n = 0; n < 16; n++) begin
         drive(4'd0, 4'(n), "R5");
         drive(4'(n), 4'd0, "R5");
      end
      // R6: unit on either side
      for (int n = 0; n < 16; n++) begin
         drive(4'd1, 4'(n), "R6");
         drive(4'(n), 4'd1, "R6");
      end
      // R4 and R3: largest product exercises every cell and the top carry
      drive(4'd15, 4'd15, "R4");
      drive(4'd15, 4'd14, "R3");
      drive(4'd10, 4'd5, "R3");

      @(negedge clk);
      repeat (3) @(posedge clk);
      #1;
      check("R8 queue drained", PW'(sbq.size()), 8'd0);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule